// File: doc/BRIEF.md
# Round-Robin Workgroup Dispatcher

This block hands the workgroups of a three-dimensional grid to a set of compute units. A kernel start loads the grid extent and the workgroup extent in each dimension. It clears the three-dimensional workgroup coordinate and the flat workgroup counter, and it marks work as pending. Each dispatch request then runs one pass. A pass visits the units one per clock in round-robin order, starting at a saved unit pointer. A unit that reports ready while work is pending gets a one-cycle start pulse. The pulse carries the coordinate and flat number of its workgroup.

After each placement the coordinate walks X first. A dimension wraps to zero, and carries into the next one, when the incremented index times the workgroup extent reaches or passes the grid extent. A carry out of Z means the grid is exhausted. The pending flag then drops and the pass ends in that cycle. The unit pointer is kept between passes and kernels. It moves on by one for every unit examined, whether that unit received work or not.

Top module: `wg_dispatch_rr`

## Requirements
- R1: After reset, no start pulse is asserted, `busy`, `work_left` and `pass_done` are low, and the first pass begins at unit 0.
- R2: When idle, `kernel_load` captures the six extents, clears the coordinate and the flat counter, and raises `work_left` in the next cycle. A `kernel_load` that arrives while a pass is running is ignored.
- R3: When idle, `pass_req` starts a pass, with `busy` high from the next cycle. The pass examines one unit per clock, starting at the saved pointer, and examines no unit twice.
- R4: The unit pointer advances modulo the unit count for every unit examined, placed or not. It keeps its value across passes and kernel loads.
- R5: `unit_start` is zero or one-hot. Bit u is high for one cycle exactly when unit u was examined while `work_left` was high and `unit_ready[u]` was high at that clock edge.
- R6: `wg_x`, `wg_y` and `wg_z` show the placed workgroup's coordinate in the cycle of its pulse. The first workgroup of a kernel is (0,0,0). X then increments, and it wraps to 0 with a carry into Y when (x+1)*size_x >= grid_x.
- R7: The same carry rule applies from Y into Z. A carry out of Z lowers `work_left` and ends the pass in the cycle of that placement.
- R8: `wg_flat` shows the placed workgroup's flat number with its pulse. It is 0 for a kernel's first workgroup and rises by 1 per placement, so the last value is one less than the product of ceil(grid/size) over the three dimensions.
- R9: `pass_done` is a one-cycle pulse in the cycle of the last examination. This is either after the full round of units or at grid exhaustion. `pass_hit` is high with it exactly when the pass placed at least one workgroup, and `busy` is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kernel_load | input | 1 | Load extents and restart the grid walk |
| grid_x | input | DIM_W | Grid extent in X |
| grid_y | input | DIM_W | Grid extent in Y |
| grid_z | input | DIM_W | Grid extent in Z |
| size_x | input | DIM_W | Workgroup extent in X (nonzero) |
| size_y | input | DIM_W | Workgroup extent in Y (nonzero) |
| size_z | input | DIM_W | Workgroup extent in Z (nonzero) |
| pass_req | input | 1 | Start one dispatch pass |
| unit_ready | input | N_UNITS | Per-unit ready level |
| unit_start | output | N_UNITS | One-cycle start pulse per unit |
| wg_x | output | DIM_W | X coordinate of placed workgroup |
| wg_y | output | DIM_W | Y coordinate of placed workgroup |
| wg_z | output | DIM_W | Z coordinate of placed workgroup |
| wg_flat | output | GID_W | Flat number of placed workgroup |
| pass_done | output | 1 | Pass finished pulse |
| pass_hit | output | 1 | Pass placed at least one workgroup (valid with pass_done) |
| busy | output | 1 | A pass is running |
| work_left | output | 1 | Workgroups remain in the grid |

## Verification
Two things can land in the same cycle: the grid running out and the round of units running out. Both end the pass. The bench provokes this with a four-workgroup grid on four always-ready units, so that the Z carry happens on the fourth unit examined. It then checks that `pass_done` fires once, in that cycle, with `busy` low and `work_left` dropping together. It also provokes exhaustion in mid-round and checks that the pass stops early and that the saved pointer resumes at the next unit.

// File: rtl/wgd_pkg.sv
package wgd_pkg;
  typedef enum logic {SCAN_IDLE, SCAN_RUN} scan_st_e;
  localparam int NDIM = 3;
endpackage

// File: rtl/wgd_id_walker.sv
module wgd_id_walker
  import wgd_pkg::*;
#(
  parameter int DIM_W = 8,
  parameter int GID_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic [NDIM-1:0][DIM_W-1:0]  grid_in,
  input  logic [NDIM-1:0][DIM_W-1:0]  size_in,
  input  logic                        step,
  output logic [NDIM-1:0][DIM_W-1:0]  id,
  output logic [GID_W-1:0]            flat,
  output logic                        pending,
  output logic                        exhaust
);
  localparam int PW = 2 * DIM_W;

  logic [NDIM-1:0][DIM_W-1:0] grid_q, size_q, id_q, nxt;
  logic [NDIM-1:0][PW-1:0]    prod;
  logic [NDIM:0]              carry;
  logic [GID_W-1:0]           flat_q;
  logic                       pend_q;

  assign carry[0] = step;

  for (genvar d = 0; d < NDIM; d++) begin : g_dim
    assign nxt[d]      = id_q[d] + 1'b1;
    assign prod[d]     = {{DIM_W{1'b0}}, nxt[d]} * {{DIM_W{1'b0}}, size_q[d]};
    assign carry[d+1]  = carry[d] && (prod[d] >= {{DIM_W{1'b0}}, grid_q[d]});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grid_q <= '0;
      size_q <= '0;
      id_q   <= '0;
      flat_q <= '0;
      pend_q <= 1'b0;
    end else if (load) begin
      grid_q <= grid_in;
      size_q <= size_in;
      id_q   <= '0;
      flat_q <= '0;
      pend_q <= 1'b1;
    end else if (step) begin
      for (int d = 0; d < NDIM; d++) begin
        if (carry[d]) id_q[d] <= carry[d+1] ? '0 : nxt[d];
      end
      flat_q <= flat_q + 1'b1;
      if (carry[NDIM]) pend_q <= 1'b0;
    end
  end

  assign id      = id_q;
  assign flat    = flat_q;
  assign pending = pend_q;
  assign exhaust = carry[NDIM];
endmodule

// File: rtl/wgd_rr_scan.sv
module wgd_rr_scan
  import wgd_pkg::*;
#(
  parameter int N_UNITS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [N_UNITS-1:0] ready,
  input  logic               pending,
  input  logic               exhaust,
  output logic               place,
  output logic [(N_UNITS > 1 ? $clog2(N_UNITS) : 1)-1:0] unit,
  output logic               scanning,
  output logic               finish,
  output logic               any_hit
);
  localparam int PTR_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(N_UNITS - 1);

  scan_st_e         st_q;
  logic [PTR_W-1:0] ptr_q, cnt_q;
  logic             any_q;

  assign scanning = (st_q == SCAN_RUN);
  assign place    = scanning && pending && ready[ptr_q];
  assign finish   = scanning && ((cnt_q == LAST) || exhaust);
  assign unit     = ptr_q;
  assign any_hit  = any_q || place;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SCAN_IDLE;
      ptr_q <= '0;
      cnt_q <= '0;
      any_q <= 1'b0;
    end else if (!scanning) begin
      if (go) begin
        st_q  <= SCAN_RUN;
        cnt_q <= '0;
        any_q <= 1'b0;
      end
    end else begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      cnt_q <= cnt_q + 1'b1;
      if (place) any_q <= 1'b1;
      if (finish) st_q <= SCAN_IDLE;
    end
  end
endmodule

// File: rtl/wg_dispatch_rr.sv
module wg_dispatch_rr
  import wgd_pkg::*;
#(
  parameter int N_UNITS = 4,
  parameter int DIM_W   = 8,
  parameter int GID_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               kernel_load,
  input  logic [DIM_W-1:0]   grid_x,
  input  logic [DIM_W-1:0]   grid_y,
  input  logic [DIM_W-1:0]   grid_z,
  input  logic [DIM_W-1:0]   size_x,
  input  logic [DIM_W-1:0]   size_y,
  input  logic [DIM_W-1:0]   size_z,
  input  logic               pass_req,
  input  logic [N_UNITS-1:0] unit_ready,
  output logic [N_UNITS-1:0] unit_start,
  output logic [DIM_W-1:0]   wg_x,
  output logic [DIM_W-1:0]   wg_y,
  output logic [DIM_W-1:0]   wg_z,
  output logic [GID_W-1:0]   wg_flat,
  output logic               pass_done,
  output logic               pass_hit,
  output logic               busy,
  output logic               work_left
);
  localparam int PTR_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;

  logic                       scanning, place, finish, any_hit, pending, exhaust;
  logic [PTR_W-1:0]           unit;
  logic [NDIM-1:0][DIM_W-1:0] id;
  logic [GID_W-1:0]           flat;
  logic [N_UNITS-1:0]         start_nxt;

  wgd_rr_scan #(.N_UNITS(N_UNITS)) u_scan (
    .clk(clk), .rst(rst), .go(pass_req), .ready(unit_ready),
    .pending(pending), .exhaust(exhaust), .place(place), .unit(unit),
    .scanning(scanning), .finish(finish), .any_hit(any_hit)
  );

  wgd_id_walker #(.DIM_W(DIM_W), .GID_W(GID_W)) u_walk (
    .clk(clk), .rst(rst), .load(kernel_load && !scanning),
    .grid_in({grid_z, grid_y, grid_x}), .size_in({size_z, size_y, size_x}),
    .step(place), .id(id), .flat(flat), .pending(pending), .exhaust(exhaust)
  );

  for (genvar u = 0; u < N_UNITS; u++) begin : g_start
    assign start_nxt[u] = place && (unit == PTR_W'(u));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unit_start <= '0;
      wg_x       <= '0;
      wg_y       <= '0;
      wg_z       <= '0;
      wg_flat    <= '0;
      pass_done  <= 1'b0;
      pass_hit   <= 1'b0;
    end else begin
      unit_start <= start_nxt;
      pass_done  <= finish;
      if (finish) pass_hit <= any_hit;
      if (place) begin
        wg_x    <= id[0];
        wg_y    <= id[1];
        wg_z    <= id[2];
        wg_flat <= flat;
      end
    end
  end

  assign busy      = scanning;
  assign work_left = pending;
endmodule

// File: rtl/wgd_checker.sv
module wgd_checker #(
  parameter int N_UNITS = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [N_UNITS-1:0] unit_ready,
  input logic [N_UNITS-1:0] unit_start,
  input logic               pass_done,
  input logic               busy,
  input logic               work_left
);
  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(unit_start)); // R5
  AST_START_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    (|unit_start) |-> ((unit_start & $past(unit_ready)) != '0)); // R5
  AST_START_IN_PASS: assert property (@(posedge clk) disable iff (rst)
    (|unit_start) |-> $past(busy)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pass_done |=> !pass_done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    pass_done |-> !busy); // R9
  AST_EXHAUST_ENDS: assert property (@(posedge clk) disable iff (rst)
    $fell(work_left) |-> pass_done); // R7
endmodule

bind wg_dispatch_rr wgd_checker #(.N_UNITS(N_UNITS)) u_chk (
  .clk(clk), .rst(rst), .unit_ready(unit_ready), .unit_start(unit_start),
  .pass_done(pass_done), .busy(busy), .work_left(work_left)
);

// File: tb/sim_wg_dispatch_rr.sv
module sim_wg_dispatch_rr;
  localparam int N = 4;
  localparam int DW = 8;
  localparam int GW = 16;

  logic clk = 1'b0, rst = 1'b1, kernel_load = 1'b0, pass_req = 1'b0;
  logic [DW-1:0] grid_x = '0, grid_y = '0, grid_z = '0;
  logic [DW-1:0] size_x = '0, size_y = '0, size_z = '0;
  logic [N-1:0]  unit_ready = '0, unit_start;
  logic [DW-1:0] wg_x, wg_y, wg_z;
  logic [GW-1:0] wg_flat;
  logic pass_done, pass_hit, busy, work_left;

  always #2 clk = ~clk;

  wg_dispatch_rr #(.N_UNITS(N), .DIM_W(DW), .GID_W(GW)) u0 (.*);

  int n_run = 0, n_fail = 0;
  int m_ptr = 0, m_flat = 0, last_flat = 0;
  int m_id[3], m_g[3], m_w[3];
  bit m_rem = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit m_advance();
    m_flat++;
    for (int d = 0; d < 3; d++) begin
      m_id[d]++;
      if (m_id[d] * m_w[d] < m_g[d]) return 1'b0;
      m_id[d] = 0;
    end
    m_rem = 1'b0;
    return 1'b1;
  endfunction

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  task automatic load_kernel(input int gx, gy, gz, wx, wy, wz);
    @(negedge clk);
    grid_x = DW'(gx); grid_y = DW'(gy); grid_z = DW'(gz);
    size_x = DW'(wx); size_y = DW'(wy); size_z = DW'(wz);
    kernel_load = 1'b1;
    @(negedge clk);
    kernel_load = 1'b0;
    m_g = '{gx, gy, gz}; m_w = '{wx, wy, wz};
    m_id = '{0, 0, 0}; m_flat = 0; m_rem = 1'b1;
    check("R2 work_left after load", work_left, 1);
  endtask

  task automatic do_pass(input logic [N-1:0] rdy, input bit kick_mid);
    bit any = 1'b0;
    bit last;
    logic [N-1:0] ep;
    int u;
    @(negedge clk);
    unit_ready = rdy; pass_req = 1'b1;
    @(negedge clk);
    pass_req = 1'b0;
    check("R3 busy after request", busy, 1);
    if (kick_mid) begin
      grid_x = 8'd1; grid_y = 8'd1; grid_z = 8'd1;
      size_x = 8'd1; size_y = 8'd1; size_z = 8'd1;
      kernel_load = 1'b1;
    end
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      kernel_load = 1'b0;
      u = m_ptr;
      m_ptr = (m_ptr + 1) % N;
      ep = '0;
      last = (k == N - 1);
      if (m_rem && rdy[u]) begin
        ep[u] = 1'b1;
        any = 1'b1;
        check("R5 start pulse", unit_start, ep);
        check("R6 wg_x", wg_x, m_id[0]);
        check("R6 wg_y", wg_y, m_id[1]);
        check("R7 wg_z", wg_z, m_id[2]);
        check("R8 wg_flat", wg_flat, m_flat);
        last_flat = wg_flat;
        if (m_advance()) begin
          last = 1'b1;
          check("R7 work_left drops at exhaustion", work_left, 0);
        end
      end else begin
        check("R5 no pulse (R4 pointer)", unit_start, 0);
      end
      check("R9 pass_done timing", pass_done, last);
      if (last) begin
        check("R9 pass_hit", pass_hit, any);
        check("R9 busy low at done", busy, 0);
        break;
      end
    end
    @(negedge clk);
    check("R9 done single cycle", pass_done, 0);
    check("R5 no stray pulse", unit_start, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 start after reset", unit_start, 0);
    check("R1 busy after reset", busy, 0);
    check("R1 work_left after reset", work_left, 0);
    check("R1 pass_done after reset", pass_done, 0);

    // R4: nothing pending, all ready: no placement, pointer still moves N
    do_pass(4'b1111, 1'b0);

    // R7/R9: exhaustion coincides with the last unit of the round
    load_kernel(4, 1, 1, 1, 1, 1);
    do_pass(4'b1111, 1'b0);
    check("R8 final flat", last_flat, 3);

    // R4: exhaustion in mid-round leaves pointer at unit 3
    load_kernel(3, 1, 1, 1, 1, 1);
    do_pass(4'b1111, 1'b0);
    load_kernel(2, 2, 1, 1, 1, 1);
    do_pass(4'b0000, 1'b0);
    do_pass(4'b1010, 1'b0);
    // R2: load during a pass is ignored
    do_pass(4'b1111, 1'b1);
    check("R2 work_left kept", work_left, m_rem);

    // R6/R7/R8 random kernels
    for (int kk = 0; kk < 10; kk++) begin
      int gx, gy, gz, wx, wy, wz, guard;
      gx = 1 + $urandom % 7; gy = 1 + $urandom % 5; gz = 1 + $urandom % 4;
      wx = 1 + $urandom % 3; wy = 1 + $urandom % 3; wz = 1 + $urandom % 2;
      load_kernel(gx, gy, gz, wx, wy, wz);
      guard = 0;
      while (m_rem && guard < 400) begin
        do_pass(N'($urandom % 16), ($urandom % 8) == 0);
        guard++;
      end
      check("R8 total workgroups", last_flat + 1,
            ceil_div(gx, wx) * ceil_div(gy, wy) * ceil_div(gz, wz));
      check("R7 work_left cleared", work_left, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule